// File: doc/BRIEF.md
# Serial Flash Master Transfer Sequencer

This block is the byte engine of a single-slave serial flash master. Software-side logic pushes 32-bit words into a transmit FIFO, each tagged with a length of one to four bytes. The engine shifts those bytes out on one data line and captures the same number of bytes from the slave. Each returned word is packed so that its bytes start from lane 0 and is then pushed into a receive FIFO. The serial clock comes from a power-of-two divider of the core clock, and its idle level and sampling phase can be selected.

Two controls are independent. The chip select is either raised and lowered by the engine according to FIFO occupancy, or forced active by a configuration bit. Shifting starts either as soon as data is queued or only after a start strobe. A start strobe is consumed once the transmit FIFO has been drained. The register interface is reduced to plain strobes and level inputs. Configuration inputs are expected to change only while the engine is idle.

The controller is a five-state machine:
- IDLE: serial clock at its idle level.
- LOAD: pops one word and preloads the shifter.
- LEAD: first half of a bit period, serial clock at its idle level.
- TRAIL: second half of a bit period, serial clock at its active level.
- DONE: pushes the received word.

The transitions are:
- IDLE→LOAD when the FIFO holds data and start is permitted.
- LOAD→LEAD always.
- LEAD→TRAIL on a divider tick (the leading edge).
- TRAIL→LEAD on a tick while bits remain (the trailing edge).
- TRAIL→DONE on the tick of the last bit.
- DONE→LOAD when another word may start, otherwise DONE→IDLE.

Top module: `spi_flash_sequencer`

## Requirements
- R1: With `cfg_cs_force` low, `cs_n` goes low in the cycle after a word is accepted into an empty transmit FIFO. It stays low while the FIFO holds data or a word is being shifted. It returns high once the FIFO is empty and the last word has completed. `cs_n` is high after reset.
- R2: With `cfg_cs_force` high, `cs_n` is low at all times, including when no data is queued and after transfers end.
- R3: With `cfg_man_start` low, shifting begins as soon as the transmit FIFO holds a word. When the FIFO is empty at a word boundary, the engine stalls with `sck` idle. A word that has started is always shifted to its end without a pause, even if the FIFO empties meanwhile.
- R4: With `cfg_man_start` high, no `sck` edge occurs until `start_cmd` is pulsed while the FIFO holds data; a pulse while the FIFO is empty has no effect. Once the engine finds the FIFO empty at a word boundary, the start is consumed, and words written afterwards wait for a new pulse.
- R5: For prescaler code N (0 to 7), each `sck` period lasts 2^(N+1) core clocks. The clock spends 2^N cycles at each level within a word.
- R6: `sck` idles low when `cfg_cpol` is 0 and high when it is 1.
- R7: With `cfg_cpha` 0, `mosi` is valid at the first edge after the word starts, and both sides sample on leading edges. With `cfg_cpha` 1, `mosi` changes on leading edges and both sides sample on trailing edges.
- R8: `tx_len` code L (0..3) makes the word L+1 bytes long. Exactly 8*(L+1) bits are shifted for it.
- R9: Bytes of a word leave in lane order, starting with lane 0 (bits 7:0). Each byte is sent most significant bit first.
- R10: Every byte sent captures one byte from `miso`, MSB first. In the word pushed to the receive FIFO, lane k holds the k-th byte captured for that word, and the lanes above the word length are zero.
- R11: A write while `tx_full` is high is dropped and never shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_presc | input | PRESC_W | Divider code N, sck = clk / 2^(N+1) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_cs_force | input | 1 | Hold chip select active |
| cfg_man_start | input | 1 | Require a start strobe before shifting |
| start_cmd | input | 1 | One-cycle start strobe |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| tx_data | input | DATA_W | Transmit word |
| tx_len | input | log2(DATA_W/8) | Byte count minus one |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Receive FIFO read strobe |
| rx_data | output | DATA_W | Head of receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest state to reach is a manual-start engine that holds queued data but no valid start. The bench gets there in two ways. It pulses the start strobe into an empty FIFO before writing. It also refills the FIFO after a drained transfer has consumed the start. In both cases the stimulus then waits many cycles and counts serial-clock edges. A full transmit FIFO can only be produced while the engine cannot drain it, so the overflow case is also built in manual-start mode before the start is given. A bench slave advances its bit stream after every sampling edge of the active phase, which makes phase errors visible in both data directions.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_LEAD,
        SQ_TRAIL,
        SQ_DONE
    } sq_state_t;

endpackage

// File: rtl/qseq_fifo.sv
module qseq_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    count;
    logic             push_ok;
    logic             pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count))); // R11

endmodule

// File: rtl/qseq_sckdiv.sv
module qseq_sckdiv #(
    parameter int PRESC_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int CNT_W = (1 << PRESC_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = ~({CNT_W{1'b1}} << presc);
    end

    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (presc != '0)) |=> !tick); // R5

endmodule

// File: rtl/qseq_engine.sv
module qseq_engine
    import qseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_cpha,
    input  logic                              cfg_man_start,
    input  logic                              start_cmd,
    input  logic                              tx_empty,
    input  logic [DATA_W-1:0]                 tx_word,
    input  logic [$clog2(DATA_W/8)-1:0]       tx_size,
    input  logic                              tick,
    input  logic                              miso,
    output logic                              tx_pop,
    output logic                              rx_push,
    output logic [DATA_W-1:0]                 rx_word,
    output logic                              div_run,
    output logic                              sck_act,
    output logic                              busy,
    output logic                              mosi
);
    localparam int NBYTES = DATA_W / 8;
    localparam int SIZE_W = $clog2(NBYTES);
    localparam int BIT_W  = $clog2(DATA_W) + 1;

    sq_state_t         state;
    sq_state_t         nstate;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] ld_seq;
    logic [BIT_W-1:0]  bits_left;
    logic [BIT_W-1:0]  ld_bits;
    logic [SIZE_W-1:0] size_q;
    logic              armed;
    logic              mosi_q;
    logic              go;

    assign go   = !tx_empty && (!cfg_man_start || armed);
    assign mosi = mosi_q;

    // Byte order on the wire: lane 0 first, so reverse lanes into the shifter.
    always_comb begin
        ld_seq = '0;
        for (int k = 0; k < NBYTES; k++) begin
            ld_seq[8*(NBYTES-1-k) +: 8] = tx_word[8*k +: 8];
        end
        ld_bits = BIT_W'((int'(tx_size) + 1) * 8);
    end

    // Right-align the captured bytes: k-th byte captured goes to lane k.
    always_comb begin
        rx_word = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (k <= int'(size_q)) begin
                rx_word[8*k +: 8] = rx_sh[8*(int'(size_q) - k) +: 8];
            end
        end
    end

    // Next-state logic.
    always_comb begin
        nstate = state;
        unique case (state)
            SQ_IDLE:  nstate = go ? SQ_LOAD : SQ_IDLE;
            SQ_LOAD:  nstate = SQ_LEAD;
            SQ_LEAD:  nstate = tick ? SQ_TRAIL : SQ_LEAD;
            SQ_TRAIL: begin
                if (tick) begin
                    nstate = (bits_left == BIT_W'(1)) ? SQ_DONE : SQ_LEAD;
                end
            end
            SQ_DONE:  nstate = go ? SQ_LOAD : SQ_IDLE;
            default:  nstate = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        tx_pop  = (state == SQ_LOAD);
        rx_push = (state == SQ_DONE);
        div_run = (state == SQ_LEAD) || (state == SQ_TRAIL);
        sck_act = (state == SQ_TRAIL);
        busy    = (state != SQ_IDLE);
    end

    // Shift datapath and start latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            bits_left <= '0;
            size_q    <= '0;
            mosi_q    <= 1'b0;
            armed     <= 1'b0;
        end else begin
            if (start_cmd && !tx_empty) begin
                armed <= 1'b1;
            end else if ((state == SQ_DONE) && tx_empty) begin
                armed <= 1'b0;
            end

            unique case (state)
                SQ_LOAD: begin
                    size_q    <= tx_size;
                    bits_left <= ld_bits;
                    rx_sh     <= '0;
                    if (!cfg_cpha) begin
                        mosi_q <= ld_seq[DATA_W-1];
                        tx_sh  <= ld_seq << 1;
                    end else begin
                        tx_sh  <= ld_seq;
                    end
                end
                SQ_LEAD: begin
                    if (tick) begin
                        if (cfg_cpha) begin
                            mosi_q <= tx_sh[DATA_W-1];
                            tx_sh  <= tx_sh << 1;
                        end else begin
                            rx_sh  <= {rx_sh[DATA_W-2:0], miso};
                        end
                    end
                end
                SQ_TRAIL: begin
                    if (tick) begin
                        bits_left <= bits_left - 1'b1;
                        if (cfg_cpha) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], miso};
                        end else if (bits_left != BIT_W'(1)) begin
                            mosi_q <= tx_sh[DATA_W-1];
                            tx_sh  <= tx_sh << 1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_man_start && !armed && !start_cmd && (state == SQ_IDLE)) |=> (state == SQ_IDLE)); // R4

    AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_IDLE) && tx_empty) |=> (state == SQ_IDLE)); // R3

    AST_TRAIL_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_TRAIL) |-> (($past(state) == SQ_LEAD) || ($past(state) == SQ_TRAIL))); // R5

    AST_WORD_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_LEAD) && $past(state == SQ_LOAD)) |-> (bits_left != '0)); // R8

endmodule

// File: rtl/spi_flash_sequencer.sv
module spi_flash_sequencer #(
    parameter int DATA_W   = 32,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int PRESC_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PRESC_W-1:0]            cfg_presc,
    input  logic                          cfg_cpol,
    input  logic                          cfg_cpha,
    input  logic                          cfg_cs_force,
    input  logic                          cfg_man_start,
    input  logic                          start_cmd,
    input  logic                          tx_wr,
    input  logic [DATA_W-1:0]             tx_data,
    input  logic [$clog2(DATA_W/8)-1:0]   tx_len,
    output logic                          tx_full,
    input  logic                          rx_rd,
    output logic [DATA_W-1:0]             rx_data,
    output logic                          rx_empty,
    output logic                          sck,
    output logic                          cs_n,
    output logic                          mosi,
    input  logic                          miso
);
    localparam int SIZE_W = $clog2(DATA_W / 8);
    localparam int TXW    = DATA_W + SIZE_W;

    logic [TXW-1:0]    tx_head;
    logic              tx_empty;
    logic              tx_pop;
    logic              rx_push;
    logic [DATA_W-1:0] rx_word;
    logic              rx_full;
    logic              div_run;
    logic              tick;
    logic              sck_act;
    logic              busy;

    qseq_fifo #(.WIDTH(TXW), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_wr),
        .wdata ({tx_len, tx_data}),
        .pop   (tx_pop),
        .rdata (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    qseq_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_rd),
        .rdata (rx_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    qseq_sckdiv #(.PRESC_W(PRESC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .presc (cfg_presc),
        .tick  (tick)
    );

    qseq_engine #(.DATA_W(DATA_W)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cpha      (cfg_cpha),
        .cfg_man_start (cfg_man_start),
        .start_cmd     (start_cmd),
        .tx_empty      (tx_empty),
        .tx_word       (tx_head[DATA_W-1:0]),
        .tx_size       (tx_head[TXW-1:DATA_W]),
        .tick          (tick),
        .miso          (miso),
        .tx_pop        (tx_pop),
        .rx_push       (rx_push),
        .rx_word       (rx_word),
        .div_run       (div_run),
        .sck_act       (sck_act),
        .busy          (busy),
        .mosi          (mosi)
    );

    assign sck  = cfg_cpol ^ sck_act;
    assign cs_n = !(cfg_cs_force || !tx_empty || busy);

    AST_SHIFT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sck_act) && sck_act) |-> (!cs_n && !rx_full || !cs_n)); // R1

endmodule

// File: tb/spi_flash_sequencer_test.sv
module spi_flash_sequencer_test;
    localparam int CLK_NS = 10;
    localparam int DW     = 32;
    localparam int TXD    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_presc = '0;
    logic          cfg_cpol = 1'b0;
    logic          cfg_cpha = 1'b0;
    logic          cfg_cs_force = 1'b0;
    logic          cfg_man_start = 1'b0;
    logic          start_cmd = 1'b0;
    logic          tx_wr = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [1:0]    tx_len = '0;
    logic          tx_full;
    logic          rx_rd = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_empty;
    logic          sck;
    logic          cs_n;
    logic          mosi;
    logic          miso = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    spi_flash_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_cs_force(cfg_cs_force), .cfg_man_start(cfg_man_start),
        .start_cmd(start_cmd), .tx_wr(tx_wr), .tx_data(tx_data), .tx_len(tx_len),
        .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Monitor / slave model state
    int   cyc = 0;
    logic prev_sck = 1'b0;
    int   nedges, mbits, mi_idx, cs_bad, nlead, last_lead;
    int   gmin, gmax, hmin, hmax, mb, salt;
    logic [7:0] mcur;
    logic [7:0] mosi_bytes [256];

    // Expectations
    logic [7:0]    exp_tx [256];
    logic [DW-1:0] exp_rx [64];
    int et, erw, err_i, sb;

    function automatic logic [7:0] sbyte(input int i);
        return 8'((i * 73 + 90 + salt) & 255);
    endfunction

    function automatic logic sbit(input int i);
        logic [7:0] b;
        b = sbyte(i / 8);
        return b[7 - (i % 8)];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && (sck !== prev_sck)) begin
            nedges++;
            if (sck != cfg_cpol) begin
                if (nlead > 0) begin
                    if (cyc - last_lead < gmin) gmin = cyc - last_lead;
                    if (cyc - last_lead > gmax) gmax = cyc - last_lead;
                end
                nlead++;
                last_lead = cyc;
            end else begin
                if (cyc - last_lead < hmin) hmin = cyc - last_lead;
                if (cyc - last_lead > hmax) hmax = cyc - last_lead;
            end
            if ((sck != cfg_cpol) == (cfg_cpha == 1'b0)) begin
                if (cs_n) cs_bad++;
                mcur = {mcur[6:0], mosi};
                mbits++;
                if ((mbits % 8 == 0) && (mb < 256)) begin
                    mosi_bytes[mb] = mcur;
                    mb++;
                end
                mi_idx++;
                miso <= sbit(mi_idx);
            end
        end
        prev_sck = sck;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clr_stats();
        nedges = 0; mbits = 0; mi_idx = 0; cs_bad = 0; nlead = 0; last_lead = 0;
        gmin = 1 << 30; gmax = 0; hmin = 1 << 30; hmax = 0; mb = 0; mcur = '0;
        et = 0; erw = 0; err_i = 0; sb = 0;
        salt = salt + 17;
        miso = sbit(0);
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic [2:0] n,
                           input logic force_cs, input logic man);
        step();
        cfg_cpol = pol; cfg_cpha = pha; cfg_presc = n;
        cfg_cs_force = force_cs; cfg_man_start = man;
        step();
        step();
        clr_stats();
    endtask

    task automatic push(input logic [DW-1:0] d, input logic [1:0] len);
        logic [DW-1:0] w;
        step();
        tx_data = d; tx_len = len; tx_wr = 1'b1;
        if (!tx_full) begin
            w = '0;
            for (int k = 0; k <= int'(len); k++) begin
                exp_tx[et] = d[8*k +: 8];
                et++;
                w[8*k +: 8] = sbyte(sb);
                sb++;
            end
            exp_rx[erw] = w;
            erw++;
        end
        step();
        tx_wr = 1'b0;
    endtask

    task automatic pulse_start();
        step();
        start_cmd = 1'b1;
        step();
        start_cmd = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 60000; i++) begin
            if (mbits >= et * 8) break;
            step();
        end
        repeat ((1 << cfg_presc) + 8) step();
    endtask

    task automatic check_stream(input string req);
        chk({req, " byte count"}, 32'(mb), 32'(et));
        for (int i = 0; i < et; i++) begin
            chk({req, " mosi byte"}, 32'(mosi_bytes[i]), 32'(exp_tx[i]));
        end
        chk({req, " cs during samples"}, 32'(cs_bad), 32'd0);
    endtask

    task automatic drain_rx(input string req);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (rx_empty) break;
            chk({req, " rx word"}, rx_data, exp_rx[err_i]);
            err_i++;
            step();
            rx_rd = 1'b1;
            step();
            rx_rd = 1'b0;
        end
        chk({req, " rx count"}, 32'(err_i), 32'(erw));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 180000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        salt = 0;
        clr_stats();
        repeat (4) step();
        rst_n = 1'b1;
        step();
        @(negedge clk);
        chk("R1 reset cs_n", 32'(cs_n), 32'd1);
        chk("R6 reset sck", 32'(sck), 32'd0);
        chk("R10 reset rx_empty", 32'(rx_empty), 32'd1);
        chk("R11 reset tx_full", 32'(tx_full), 32'd0);

        // R1 R9 R5: auto select, auto start, fastest clock, one 4-byte word
        set_cfg(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
        push(32'h44332211, 2'd3);
        @(negedge clk);
        chk("R1 cs_n low after write", 32'(cs_n), 32'd0);
        wait_done();
        check_stream("R9 lane order");
        chk("R9 first byte", 32'(mosi_bytes[0]), 32'h11);
        chk("R5 period N=0", 32'(gmax), 32'd2);
        chk("R3 no mid-word pause", 32'(gmin), 32'd2);
        chk("R5 half N=0", 32'(hmax), 32'd1);
        @(negedge clk);
        chk("R1 cs_n released", 32'(cs_n), 32'd1);
        drain_rx("R10");

        // R8 R10: size tags
        set_cfg(1'b0, 1'b0, 3'd1, 1'b0, 1'b0);
        push(32'hA1B2C3D4, 2'd0);
        push(32'h0BADF00D, 2'd1);
        push(32'h13579BDF, 2'd2);
        wait_done();
        check_stream("R8 short words");
        drain_rx("R10 right aligned");

        // R6 R7 R5: idle high, second-edge sampling, N=2
        set_cfg(1'b1, 1'b1, 3'd2, 1'b0, 1'b0);
        @(negedge clk);
        chk("R6 sck idles high", 32'(sck), 32'd1);
        push(32'h00009C5A, 2'd1);
        wait_done();
        check_stream("R7 phase 1");
        chk("R5 period N=2", 32'(gmax), 32'd8);
        chk("R5 period N=2 min", 32'(gmin), 32'd8);
        chk("R5 half N=2", 32'(hmin), 32'd4);
        drain_rx("R7 phase 1");

        // R5 slowest divider
        set_cfg(1'b0, 1'b1, 3'd7, 1'b0, 1'b0);
        push(32'h000000E7, 2'd0);
        wait_done();
        check_stream("R5 N=7");
        chk("R5 period N=7", 32'(gmax), 32'd256);
        chk("R5 half N=7", 32'(hmax), 32'd128);
        drain_rx("R5 N=7");

        // R4 manual start
        set_cfg(1'b0, 1'b0, 3'd0, 1'b0, 1'b1);
        pulse_start();
        push(32'h11223344, 2'd3);
        repeat (60) step();
        chk("R4 early start ignored", 32'(nedges), 32'd0);
        @(negedge clk);
        chk("R1 cs_n low while queued", 32'(cs_n), 32'd0);
        pulse_start();
        wait_done();
        check_stream("R4 after start");
        push(32'h55667788, 2'd1);
        begin
            int e0;
            e0 = nedges;
            repeat (60) step();
            chk("R4 start consumed", 32'(nedges - e0), 32'd0);
        end
        pulse_start();
        wait_done();
        check_stream("R4 restarted");
        drain_rx("R4");

        // R2 forced select
        set_cfg(1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R2 forced with empty fifo", 32'(cs_n), 32'd0);
        push(32'hCAFEBABE, 2'd3);
        wait_done();
        check_stream("R2 forced transfer");
        @(negedge clk);
        chk("R2 forced after transfer", 32'(cs_n), 32'd0);
        drain_rx("R2");
        set_cfg(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R1 release after force cleared", 32'(cs_n), 32'd1);

        // R3 stall while empty, resume on write
        set_cfg(1'b0, 1'b1, 3'd1, 1'b0, 1'b0);
        push(32'h000000A5, 2'd0);
        wait_done();
        begin
            int e0;
            e0 = nedges;
            repeat (40) step();
            chk("R3 stalled while empty", 32'(nedges - e0), 32'd0);
        end
        @(negedge clk);
        chk("R3 sck idle in stall", 32'(sck), 32'd0);
        push(32'h0000005A, 2'd0);
        wait_done();
        check_stream("R3 resumed");
        drain_rx("R3");

        // R11 overflow dropped
        set_cfg(1'b0, 1'b0, 3'd0, 1'b0, 1'b1);
        for (int i = 0; i < TXD + 2; i++) begin
            push(32'(i * 3 + 1), 2'd0);
        end
        @(negedge clk);
        chk("R11 tx_full", 32'(tx_full), 32'd1);
        pulse_start();
        wait_done();
        repeat (20) step();
        check_stream("R11 only accepted words");
        chk("R11 accepted bytes", 32'(et), 32'(TXD));
        drain_rx("R11");

        // Random mixes
        for (int r = 0; r < 6; r++) begin
            int nw;
            set_cfg(1'($urandom % 2), 1'($urandom % 2), 3'($urandom % 3),
                    1'($urandom % 2), 1'b0);
            nw = 1 + ($urandom % 5);
            for (int w = 0; w < nw; w++) begin
                push($urandom, 2'($urandom % 4));
            end
            wait_done();
            check_stream("R7 R9 random");
            drain_rx("R10 random");
        end

        finish_run();
    end

endmodule